// File: doc/BRIEF.md
# Privilege-Gated Counter Read Unit

This block answers reads of the thirty-two counter registers of a processor hart: the cycle count, the wall-clock time, the retired-instruction count and the performance counters numbered 3 to 31. It does not keep the counts. It takes them as live inputs and decides, for each read, whether the current privilege level may see the value. The decision uses two counter-enable masks that the block holds. One mask is owned by machine mode and the other by supervisor mode.

A machine-mode read always returns the live value. A supervisor-mode read is allowed by the bit of the machine-owned mask at the counter's index. A user-mode read is allowed by the same bit of the supervisor-owned mask. A read that is not allowed does not trap. It returns zero and raises a disabled flag. Performance counters 3 to 31 have no events of their own, so each of them returns the cycle count. An index outside the counter range, or a privilege code that is not defined, gives zero with an illegal flag. Every result is registered and appears one cycle after the read strobe.

Top module: `ctr_read_gate`

## Requirements
- R1: After reset, rd_valid_o, rd_data_o, rd_disabled_o and rd_illegal_o are all zero, and both enable masks hold 0x7. With these masks only counters 0, 1 and 2 can be read from supervisor and user modes.
- R2: Privilege codes are 2'b11 machine, 2'b01 supervisor and 2'b00 user. A machine-mode read of any index from 0 to 31 is never disabled.
- R3: A supervisor-mode read of index k is permitted exactly when bit k of the machine-owned mask is 1. The supervisor-owned mask has no effect on it.
- R4: A user-mode read of index k is permitted exactly when bit k of the supervisor-owned mask is 1. The machine-owned mask has no effect on it.
- R5: A denied read returns rd_data_o = 0 with rd_disabled_o = 1 and rd_illegal_o = 0.
- R6: When a read is permitted, index 0 returns cycle_i, index 1 returns time_i and index 2 returns instret_i. Each input is taken in the cycle of the strobe.
- R7: Indices 3 to 31 return cycle_i when permitted.
- R8: An index of 32 or above, or the privilege code 2'b10, returns rd_data_o = 0 with rd_illegal_o = 1 and rd_disabled_o = 0.
- R9: rd_valid_o is 1 in exactly the cycle after each cycle in which rd_en_i is 1. Whenever rd_valid_o is 0, the data output and both flags are 0.
- R10: A mask write is seen only by reads strobed in later cycles. A read strobed in the same cycle as the write uses the previous mask.
- R11: Writing one enable mask leaves the other mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege level (11 M, 01 S, 00 U) |
| rd_en_i | input | 1 | Read strobe |
| csr_idx_i | input | IDX_W | Counter index of the read |
| cycle_i | input | DATA_W | Live cycle count |
| time_i | input | DATA_W | Live time value |
| instret_i | input | DATA_W | Live retired-instruction count |
| m_mask_we_i | input | 1 | Write strobe for the machine-owned enable mask |
| m_mask_wdata_i | input | 32 | New machine-owned mask value |
| s_mask_we_i | input | 1 | Write strobe for the supervisor-owned enable mask |
| s_mask_wdata_i | input | 32 | New supervisor-owned mask value |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | DATA_W | Read result, zero if denied or illegal |
| rd_disabled_o | output | 1 | The read was denied by a mask |
| rd_illegal_o | output | 1 | Bad index or bad privilege code |

## Verification
A mask write and a read that depends on that mask can land on the same clock edge. The bench provokes this by strobing a supervisor read of the cycle counter together with a write that clears the machine-owned mask. It expects the live value from the old mask, and then a denied zero on the read that follows. A user read is also strobed while the supervisor-owned mask is being set, to confirm that the new bit does not apply to that read.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int NUM_CTR  = 32;
    localparam int SEL_W    = $clog2(NUM_CTR);
    localparam int MASK_W   = NUM_CTR;

    localparam logic [MASK_W-1:0] MASK_RESET = 32'h0000_0007;

    localparam int IDX_CYCLE   = 0;
    localparam int IDX_TIME    = 1;
    localparam int IDX_INSTRET = 2;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_BAD = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef struct packed {
        logic illegal;
        logic denied;
    } access_t;

    function automatic logic mask_allows(input logic [MASK_W-1:0] mask,
                                         input logic [SEL_W-1:0]  sel);
        return mask[sel];
    endfunction

endpackage

// File: rtl/ctr_enable_reg.sv
module ctr_enable_reg
    import ctr_pkg::*;
#(
    parameter int                WIDTH     = MASK_W,
    parameter logic [WIDTH-1:0]  RESET_VAL = MASK_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= RESET_VAL;
        end else if (we_i) begin
            q_o <= wdata_i;
        end
    end

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> q_o == RESET_VAL);

    assert_hold_unwritten_R11: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(q_o));

endmodule

// File: rtl/ctr_access_check.sv
module ctr_access_check
    import ctr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [1:0]        priv_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [MASK_W-1:0] m_mask_i,
    input  logic [MASK_W-1:0] s_mask_i,
    output access_t           acc_o
);

    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_CTR);

    logic [SEL_W-1:0] sel;
    priv_e            priv;

    assign sel  = idx_i[SEL_W-1:0];
    assign priv = priv_e'(priv_i);

    always_comb begin
        acc_o = '0;
        if (idx_i >= IDX_LIMIT) begin
            acc_o.illegal = 1'b1;
        end else begin
            unique case (priv)
                PRIV_M:  acc_o.denied = 1'b0;
                PRIV_S:  acc_o.denied = !mask_allows(m_mask_i, sel);
                PRIV_U:  acc_o.denied = !mask_allows(s_mask_i, sel);
                default: acc_o.illegal = 1'b1;
            endcase
        end
    end

    always_comb begin
        assert (!(acc_o.illegal && acc_o.denied))
            else $error("assert_flags_exclusive_R8");
    end

endmodule

// File: rtl/ctr_value_sel.sv
module ctr_value_sel
    import ctr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] cycle_i,
    input  logic [DATA_W-1:0] time_i,
    input  logic [DATA_W-1:0] instret_i,
    output logic [DATA_W-1:0] value_o
);

    logic [DATA_W-1:0] src [NUM_CTR];

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_src
        if (g == IDX_TIME) begin : g_time
            assign src[g] = time_i;
        end else if (g == IDX_INSTRET) begin : g_inst
            assign src[g] = instret_i;
        end else begin : g_cyc
            assign src[g] = cycle_i;
        end
    end

    assign value_o = src[sel_i];

endmodule

// File: rtl/ctr_read_gate.sv
module ctr_read_gate
    import ctr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        priv_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  csr_idx_i,
    input  logic [DATA_W-1:0] cycle_i,
    input  logic [DATA_W-1:0] time_i,
    input  logic [DATA_W-1:0] instret_i,
    input  logic              m_mask_we_i,
    input  logic [31:0]       m_mask_wdata_i,
    input  logic              s_mask_we_i,
    input  logic [31:0]       s_mask_wdata_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_disabled_o,
    output logic              rd_illegal_o
);

    logic [MASK_W-1:0] m_mask;
    logic [MASK_W-1:0] s_mask;
    access_t           acc;
    logic [DATA_W-1:0] live_val;

    ctr_enable_reg #(.WIDTH(MASK_W), .RESET_VAL(MASK_RESET)) u_m_mask (
        .clk     (clk),
        .rst     (rst),
        .we_i    (m_mask_we_i),
        .wdata_i (m_mask_wdata_i),
        .q_o     (m_mask)
    );

    ctr_enable_reg #(.WIDTH(MASK_W), .RESET_VAL(MASK_RESET)) u_s_mask (
        .clk     (clk),
        .rst     (rst),
        .we_i    (s_mask_we_i),
        .wdata_i (s_mask_wdata_i),
        .q_o     (s_mask)
    );

    ctr_access_check #(.IDX_W(IDX_W)) u_check (
        .priv_i   (priv_i),
        .idx_i    (csr_idx_i),
        .m_mask_i (m_mask),
        .s_mask_i (s_mask),
        .acc_o    (acc)
    );

    ctr_value_sel #(.DATA_W(DATA_W)) u_sel (
        .sel_i     (csr_idx_i[SEL_W-1:0]),
        .cycle_i   (cycle_i),
        .time_i    (time_i),
        .instret_i (instret_i),
        .value_o   (live_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o    <= 1'b0;
            rd_data_o     <= '0;
            rd_disabled_o <= 1'b0;
            rd_illegal_o  <= 1'b0;
        end else begin
            rd_valid_o    <= rd_en_i;
            rd_disabled_o <= rd_en_i && acc.denied;
            rd_illegal_o  <= rd_en_i && acc.illegal;
            if (rd_en_i && !acc.denied && !acc.illegal) begin
                rd_data_o <= live_val;
            end else begin
                rd_data_o <= '0;
            end
        end
    end

    assert_valid_follows_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rd_valid_o);

    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> !rd_valid_o);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_valid_o |-> (rd_data_o == '0 && !rd_disabled_o && !rd_illegal_o));

    assert_denied_zero_R5: assert property (@(posedge clk) disable iff (rst)
        rd_disabled_o |-> (rd_data_o == '0 && !rd_illegal_o));

    assert_machine_open_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && priv_i == 2'b11 && csr_idx_i < IDX_W'(NUM_CTR)) |=> !rd_disabled_o);

    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rd_illegal_o |-> rd_data_o == '0);

endmodule

// File: tb/ctr_read_gate_tb_top.sv
module ctr_read_gate_tb_top;

    localparam int DATA_W = 64;
    localparam int IDX_W  = 6;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        priv_i;
    logic              rd_en_i;
    logic [IDX_W-1:0]  csr_idx_i;
    logic [DATA_W-1:0] cycle_i, time_i, instret_i;
    logic              m_mask_we_i, s_mask_we_i;
    logic [31:0]       m_mask_wdata_i, s_mask_wdata_i;
    logic              rd_valid_o;
    logic [DATA_W-1:0] rd_data_o;
    logic              rd_disabled_o, rd_illegal_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 0;
    logic [31:0] m_model, s_model;

    always #10 clk = ~clk;

    ctr_read_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dut_i (.*);

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic read_ctr(input logic [1:0] p, input logic [IDX_W-1:0] idx);
        @(negedge clk);
        priv_i = p; csr_idx_i = idx; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic expect_read(input string req, input logic [1:0] p, input int idx);
        logic [DATA_W-1:0] ev;
        logic ed, ei;
        ed = 0; ei = 0; ev = '0;
        if (idx > 31 || p == 2'b10) ei = 1;
        else if (p == 2'b01) ed = !m_model[idx];
        else if (p == 2'b00) ed = !s_model[idx];
        if (!ed && !ei) ev = (idx == 1) ? time_i : (idx == 2) ? instret_i : cycle_i;
        read_ctr(p, IDX_W'(idx));
        check(req, "valid", DATA_W'(rd_valid_o), 1);
        check(req, "data", rd_data_o, ev);
        check(req, "disabled", DATA_W'(rd_disabled_o), DATA_W'(ed));
        check(req, "illegal", DATA_W'(rd_illegal_o), DATA_W'(ei));
    endtask

    task automatic write_masks(input bit wm, input logic [31:0] mv,
                               input bit ws, input logic [31:0] sv);
        @(negedge clk);
        m_mask_we_i = wm; m_mask_wdata_i = mv;
        s_mask_we_i = ws; s_mask_wdata_i = sv;
        @(negedge clk);
        m_mask_we_i = 0; s_mask_we_i = 0;
        if (wm) m_model = mv;
        if (ws) s_model = sv;
    endtask

    task automatic t_reset;
        check("R1", "valid", DATA_W'(rd_valid_o), 0);
        check("R1", "data", rd_data_o, 0);
        check("R1", "flags", DATA_W'({rd_disabled_o, rd_illegal_o}), 0);
        for (int i = 0; i < 4; i++) expect_read("R1", 2'b01, i);
        for (int i = 0; i < 4; i++) expect_read("R1", 2'b00, i);
    endtask

    task automatic t_machine;
        write_masks(1, 32'h0, 1, 32'h0);
        for (int i = 0; i < 32; i++) expect_read("R2", 2'b11, i);
    endtask

    task automatic t_super;
        write_masks(1, 32'hA5A5_0F0F, 1, 32'h5A5A_F0F0);
        for (int i = 0; i < 32; i++) expect_read("R3", 2'b01, i);
        expect_read("R5", 2'b01, 4);
    endtask

    task automatic t_user;
        for (int i = 0; i < 32; i++) expect_read("R4", 2'b00, i);
        expect_read("R5", 2'b00, 0);
    endtask

    task automatic t_values;
        write_masks(1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF);
        cycle_i = 64'h0123_4567_89AB_CDEF; time_i = 64'hFEDC_BA98_7654_3210;
        instret_i = 64'h0F0F_0F0F_F0F0_F0F0;
        expect_read("R6", 2'b00, 0);
        expect_read("R6", 2'b01, 1);
        expect_read("R6", 2'b11, 2);
        for (int i = 3; i < 32; i += 7) expect_read("R7", 2'b00, i);
        expect_read("R7", 2'b01, 31);
    endtask

    task automatic t_illegal;
        expect_read("R8", 2'b11, 32);
        expect_read("R8", 2'b11, 63);
        expect_read("R8", 2'b10, 0);
        expect_read("R8", 2'b10, 5);
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        check("R9", "idle valid", DATA_W'(rd_valid_o), 0);
        check("R9", "idle data", rd_data_o, 0);
    endtask

    task automatic t_same_cycle;
        write_masks(1, 32'h0000_0007, 1, 32'h0);
        @(negedge clk);
        m_mask_we_i = 1; m_mask_wdata_i = 32'h0;
        priv_i = 2'b01; csr_idx_i = 0; rd_en_i = 1;
        @(negedge clk);
        m_mask_we_i = 0; rd_en_i = 0;
        check("R10", "old mask data", rd_data_o, cycle_i);
        check("R10", "old mask disabled", DATA_W'(rd_disabled_o), 0);
        m_model = 32'h0;
        expect_read("R10", 2'b01, 0);
        @(negedge clk);
        s_mask_we_i = 1; s_mask_wdata_i = 32'h0000_0100;
        priv_i = 2'b00; csr_idx_i = 8; rd_en_i = 1;
        @(negedge clk);
        s_mask_we_i = 0; rd_en_i = 0;
        check("R10", "user old mask disabled", DATA_W'(rd_disabled_o), 1);
        s_model = 32'h0000_0100;
        expect_read("R10", 2'b00, 8);
    endtask

    task automatic t_independent;
        write_masks(1, 32'h0000_0002, 1, 32'h0000_0004);
        write_masks(1, 32'h0000_0008, 0, 32'hFFFF_FFFF);
        expect_read("R11", 2'b00, 2);
        expect_read("R11", 2'b00, 3);
        write_masks(0, 32'hFFFF_FFFF, 1, 32'h0);
        expect_read("R11", 2'b01, 3);
        expect_read("R11", 2'b01, 2);
    endtask

    initial begin
        rst = 1; priv_i = 2'b11; rd_en_i = 0; csr_idx_i = '0;
        cycle_i = 64'h1111_0000_0000_00A5; time_i = 64'h2222_0000_0000_005A;
        instret_i = 64'h3333_0000_0000_0033;
        m_mask_we_i = 0; s_mask_we_i = 0; m_mask_wdata_i = '0; s_mask_wdata_i = '0;
        m_model = 32'h7; s_model = 32'h7;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_machine();
        t_super();
        t_user();
        t_values();
        t_illegal();
        t_idle();
        t_same_cycle();
        t_independent();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule